// File: doc/BRIEF.md
# Card Host Interrupt Aggregator

This block collects the interrupt events of a removable-card host controller and reduces them to one interrupt line. Each source delivers a one-cycle event pulse that is latched in a local status register. A local enable register decides which latched bits count as pending. The pending state feeds bit 0 of a global status register. That register also carries bit 1 for a sibling controller that shares the same interrupt line.

Two independent global registers control the global level. The status-enable register decides whether a global bit may be recorded at all. The signal-enable register decides whether a recorded bit drives the interrupt output. Both status registers are write-one-to-clear. One event source is generated inside the block: the two active-low card-detect pins are synchronised, and every change in whether the card is fully seated raises a local event. Software reaches all registers through a simple single-cycle read/write port addressed by byte offset. Reads are combinational.

Top module: `cf_irq_aggregator`

## Requirements
- R1: After reset the local status, local enable, global status, global status-enable and global signal-enable registers read zero and `irq_out` is low. The card status register at 0x000 reads 0x0000000C while both detect pins are high.
- R2: A one-cycle pulse on `evt_in[i]` for i in {1,2,3,8,9,10,11} sets bit i of local status (offset 0x004), which is visible after that clock edge. `evt_in[0]` and `evt_in[7:4]` have no effect. Local status bits 4–7 and 12–31 always read zero.
- R3: Writing a value to local status clears exactly the bits written as 1 and leaves all other bits unchanged.
- R4: When an event arrives on the same edge as a write-one-to-clear of the same local bit, the bit stays set.
- R5: Local enable (offset 0x008) is read/write only in bits 0–3 and 8–11. All other bits read zero.
- R6: Global status bit 0 (offset 0x800) is set on the edge after any local status bit is set together with its local enable bit, provided global status-enable bit 0 is 1. It stays set until it is cleared by writing 1 to bit 0. It sets again while a pending local bit remains.
- R7: While global status-enable bit 0 (offset 0x804) is 0, global status bit 0 is never set. Clearing signal-enable does not clear global status.
- R8: Global status bit 1 is set on the edge after `sib_req` is high, provided global status-enable bit 1 is 1. It is cleared by writing 1 to bit 1 of offset 0x800.
- R9: Writing to global status clears exactly the bits written as 1.
- R10: `irq_out` is high exactly when some global status bit is set and the matching bit of signal-enable (offset 0x808) is 1. It follows those registers with no extra delay.
- R11: Card status bit 2 shows `cd1_n` and bit 3 shows `cd2_n`, each after a two-flop synchroniser.
- R12: The card counts as present only when both synchronised detect pins are low. Every change of presence sets local status bit 0 on the third edge after the pin change that caused it. A change of one pin that leaves presence unchanged raises no event.
- R13: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe, one access per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_in | input | 12 | One-cycle event pulses, one per local source bit |
| cd1_n | input | 1 | First card-detect pin, active low, asynchronous |
| cd2_n | input | 1 | Second card-detect pin, active low, asynchronous |
| sib_req | input | 1 | Pending request of the sibling controller |
| irq_out | output | 1 | Shared interrupt line |

## Verification
The bench goes after ordering collisions. An event that lands on the same edge as its own clear must survive; a design that lets the clear win would lose an interrupt. Clearing the global bit while a local bit is still pending must leave the global bit set; a design that drops it would hang software that clears in the wrong order. Gating is checked at both levels and for the sibling bit: a design that wires the interrupt line to status alone, or records the global bit without status-enable, raises spurious interrupts. The card-detect tests use a half-seated card and count the synchroniser latency. A design that reacts to a single pin, or that skips a sync stage, shows an event at the wrong edge or a false insertion.

// File: rtl/cf_irq_aggregator.sv
module cf_irq_aggregator #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SRC_W = 12,
  parameter int SYNC_STAGES = 2,
  parameter logic [SRC_W-1:0] SRC_MASK = 'hF0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [SRC_W-1:0]  evt_in,
  input  logic              cd1_n,
  input  logic              cd2_n,
  input  logic              sib_req,
  output logic              irq_out
);

  localparam int GLB_W = 2;
  localparam logic [ADDR_W-1:0] OFF_CARD = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFF_LSTS = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFF_LEN  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] OFF_GSTS = ADDR_W'(12'h800);
  localparam logic [ADDR_W-1:0] OFF_GEN  = ADDR_W'(12'h804);
  localparam logic [ADDR_W-1:0] OFF_GSIG = ADDR_W'(12'h808);

  logic [SYNC_STAGES-1:0] sync_a, sync_b;
  logic                   pres_q;
  logic [SRC_W-1:0]       lsts, len;
  logic [GLB_W-1:0]       gsts, gen, gsig;

  wire cd1_s    = sync_a[SYNC_STAGES-1];
  wire cd2_s    = sync_b[SYNC_STAGES-1];
  wire pres_now = ~cd1_s & ~cd2_s;
  wire det_evt  = pres_now ^ pres_q;

  wire wr_lsts = reg_we && (reg_addr == OFF_LSTS);
  wire wr_len  = reg_we && (reg_addr == OFF_LEN);
  wire wr_gsts = reg_we && (reg_addr == OFF_GSTS);
  wire wr_gen  = reg_we && (reg_addr == OFF_GEN);
  wire wr_gsig = reg_we && (reg_addr == OFF_GSIG);

  wire [SRC_W-1:0] set_vec  = ({evt_in[SRC_W-1:1], det_evt}) & SRC_MASK;
  wire [SRC_W-1:0] lclr     = wr_lsts ? reg_wdata[SRC_W-1:0] : '0;
  wire             lpend    = |(lsts & len);
  wire [GLB_W-1:0] gset     = {sib_req & gen[1], lpend & gen[0]};
  wire [GLB_W-1:0] gclr     = wr_gsts ? reg_wdata[GLB_W-1:0] : '0;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[DATA_W-1:SRC_W], evt_in[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '1;
      sync_b <= '1;
      pres_q <= 1'b0;
    end else begin
      sync_a <= {sync_a[SYNC_STAGES-2:0], cd1_n};
      sync_b <= {sync_b[SYNC_STAGES-2:0], cd2_n};
      pres_q <= pres_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsts <= '0;
      len  <= '0;
    end else begin
      lsts <= (lsts & ~lclr) | set_vec;
      if (wr_len) len <= reg_wdata[SRC_W-1:0] & SRC_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gsts <= '0;
      gen  <= '0;
      gsig <= '0;
    end else begin
      gsts <= (gsts & ~gclr) | gset;
      if (wr_gen)  gen  <= reg_wdata[GLB_W-1:0];
      if (wr_gsig) gsig <= reg_wdata[GLB_W-1:0];
    end
  end

  assign irq_out = |(gsts & gsig);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_CARD: reg_rdata[3:2]       = {cd2_s, cd1_s};
      OFF_LSTS: reg_rdata[SRC_W-1:0] = lsts;
      OFF_LEN:  reg_rdata[SRC_W-1:0] = len;
      OFF_GSTS: reg_rdata[GLB_W-1:0] = gsts;
      OFF_GEN:  reg_rdata[GLB_W-1:0] = gen;
      OFF_GSIG: reg_rdata[GLB_W-1:0] = gsig;
      default:  reg_rdata = '0;
    endcase
  end

  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((lsts & $past(set_vec)) == $past(set_vec)));

  a_r3_clear_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lsts && ((reg_wdata[SRC_W-1:0] & set_vec) == '0))
      |=> ((lsts & $past(reg_wdata[SRC_W-1:0] & SRC_MASK)) == '0));

  a_r6_global_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (lpend && gen[0]) |=> gsts[0]);

  a_r7_status_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen[0] && !gsts[0]) |=> !gsts[0]);

  a_r12_detect_event: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_now != pres_q) |=> lsts[0]);

  a_r10_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
    (gsig == '0) |-> !irq_out);

endmodule

// File: tb/tb_cf_irq_aggregator.sv
module tb_cf_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] evt_in = '0;
  logic        cd1_n = 1'b1, cd2_n = 1'b1, sib_req = 1'b0;
  logic        irq_out;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  cf_irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .cd1_n(cd1_n), .cd2_n(cd2_n), .sib_req(sib_req), .irq_out(irq_out));

  // behavioural reference model
  bit [11:0] m_lsts, m_len, n_lsts, n_len;
  bit [1:0]  m_gsts, m_gen, m_gsig, n_gsts;
  bit        m_a1 = 1, m_a2 = 1, m_b1 = 1, m_b2 = 1, m_pres = 0;
  bit        pres, det, g0set, g1set;

  function automatic bit implemented(int i);
    return (i < 4) || (i >= 8 && i < 12);
  endfunction

  function automatic bit [31:0] model_read(bit [11:0] a);
    case (a)
      12'h000: return {28'd0, m_b2, m_a2, 2'b00};
      12'h004: return {20'd0, m_lsts};
      12'h008: return {20'd0, m_len};
      12'h800: return {30'd0, m_gsts};
      12'h804: return {30'd0, m_gen};
      12'h808: return {30'd0, m_gsig};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lsts = 0; m_len = 0; m_gsts = 0; m_gen = 0; m_gsig = 0;
      m_a1 = 1; m_a2 = 1; m_b1 = 1; m_b2 = 1; m_pres = 0;
    end else begin
      pres = !m_a2 && !m_b2;
      det = (pres != m_pres);
      n_len = m_len;
      for (int i = 0; i < 12; i++) begin
        bit ev, clr;
        ev = (i == 0) ? det : evt_in[i];
        clr = reg_we && reg_addr == 12'h004 && reg_wdata[i];
        n_lsts[i] = implemented(i) && ((m_lsts[i] && !clr) || ev);
        if (reg_we && reg_addr == 12'h008) n_len[i] = implemented(i) && reg_wdata[i];
      end
      g0set = ((m_lsts & m_len) != 0) && m_gen[0];
      g1set = sib_req && m_gen[1];
      n_gsts = m_gsts;
      if (reg_we && reg_addr == 12'h800) n_gsts = n_gsts & ~reg_wdata[1:0];
      if (g0set) n_gsts[0] = 1;
      if (g1set) n_gsts[1] = 1;
      if (reg_we && reg_addr == 12'h804) m_gen = reg_wdata[1:0];
      if (reg_we && reg_addr == 12'h808) m_gsig = reg_wdata[1:0];
      m_lsts = n_lsts; m_len = n_len; m_gsts = n_gsts;
      m_a2 = m_a1; m_a1 = cd1_n; m_b2 = m_b1; m_b1 = cd2_n; m_pres = pres;
    end
  end

  // per-cycle comparison against the model (R2, R10 and all register state)
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      n_checks++;
      if (reg_rdata !== model_read(reg_addr)) begin
        n_errors++;
        $display("FAIL R2/R6 model read @%h act=%h exp=%h", reg_addr, reg_rdata, model_read(reg_addr));
      end
      n_checks++;
      if (irq_out !== ((m_gsts & m_gsig) != 0)) begin
        n_errors++;
        $display("FAIL R10 model irq act=%0b exp=%0b", irq_out, (m_gsts & m_gsig) != 0);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [11:0] ev);
    evt_in = ev;
    @(negedge clk);
    evt_in = '0;
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset values
    rd(12'h004, 0, "R1 lsts");
    rd(12'h008, 0, "R1 len");
    rd(12'h800, 0, "R1 gsts");
    rd(12'h804, 0, "R1 gen");
    rd(12'h808, 0, "R1 gsig");
    chk("R1 irq", irq_out, 0);
    rd(12'h000, 32'hC, "R1 card");

    // R5 implemented enable bits
    wr(12'h008, 32'hFFFF);
    rd(12'h008, 32'hF0F, "R5 len mask");
    wr(12'h804, 3);
    wr(12'h808, 1);

    // R2 latch, R6 global, R10 line
    pulse(12'h200);
    rd(12'h004, 32'h200, "R2 latch bit9");
    chk("R10 irq high", irq_out, 1);
    rd(12'h800, 1, "R6 global set");
    wr(12'h800, 1);
    rd(12'h800, 1, "R6 reassert while pending");

    // R3 exact clear
    pulse(12'h400);
    wr(12'h004, 32'h200);
    rd(12'h004, 32'h400, "R3 exact clear");

    // R4 event wins over clear
    evt_in = 12'h400;
    wr(12'h004, 32'h400);
    evt_in = '0;
    rd(12'h004, 32'h400, "R4 set wins");

    // R9 global clear after local clear
    wr(12'h004, 32'hFFF);
    wr(12'h800, 1);
    rd(12'h800, 0, "R9 global clear");
    chk("R10 irq low", irq_out, 0);

    // R2 ignored sources
    pulse(12'h0F1);
    rd(12'h004, 0, "R2 ignored bits");

    // R6 local enable gating
    wr(12'h008, 32'h70F);
    pulse(12'h800);
    rd(12'h004, 32'h800, "R2 latch disabled src");
    rd(12'h800, 0, "R6 local gate");
    chk("R10 irq gated local", irq_out, 0);

    // R7 status-enable gating
    wr(12'h804, 2);
    wr(12'h008, 32'hF0F);
    step();
    rd(12'h800, 0, "R7 status-enable off");
    wr(12'h804, 3);
    step();
    rd(12'h800, 1, "R7 status-enable on");

    // R10 signal-enable gating, R7 independence
    wr(12'h808, 0);
    chk("R10 sig off", irq_out, 0);
    rd(12'h800, 1, "R7 status kept");
    wr(12'h808, 1);
    chk("R10 sig on", irq_out, 1);
    wr(12'h004, 32'hFFF);
    wr(12'h800, 3);
    rd(12'h800, 0, "R9 cleared");

    // R8 sibling bit
    sib_req = 1'b1;
    step();
    sib_req = 1'b0;
    rd(12'h800, 2, "R8 sibling set");
    chk("R10 sibling masked", irq_out, 0);
    wr(12'h808, 3);
    chk("R10 sibling signals", irq_out, 1);
    wr(12'h800, 2);
    rd(12'h800, 0, "R8 sibling clear");
    wr(12'h804, 1);
    sib_req = 1'b1;
    step();
    step();
    sib_req = 1'b0;
    rd(12'h800, 0, "R8 sibling gated");
    wr(12'h804, 3);

    // R11, R12 card detect
    cd1_n = 1'b0;
    repeat (4) step();
    rd(12'h000, 32'h8, "R11 card pins");
    rd(12'h004, 0, "R12 half seated");
    cd2_n = 1'b0;
    step();
    step();
    rd(12'h004, 0, "R11 sync latency");
    rd(12'h004, 1, "R12 insert event");
    rd(12'h000, 0, "R11 both low");
    wr(12'h004, 1);
    rd(12'h004, 0, "R12 no repeat");
    cd1_n = 1'b1;
    repeat (3) step();
    rd(12'h004, 1, "R12 removal event");

    // R13 unmapped
    rd(12'h00C, 0, "R13 unmapped");
    rd(12'h7FC, 0, "R13 unmapped high");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule